// File: doc/BRIEF.md
# CPU-Side Bidirectional I/O Port

This block is a small 8-bit general-purpose port that sits on a processor's memory bus at the two lowest addresses. One register sets the direction of each pin and the other holds the value to drive. Each pin is driven only while its direction bit is set to output. The pin side uses three separate buses: input, output and per-bit output enable. The pad ring joins them into real bidirectional pins.

The CPU bus is a plain synchronous interface made of an address, a write strobe, write data and read data. A write is taken on the rising clock edge while the strobe is high. A read is combinational and is answered in the same cycle. The block has no stream traffic, so the bus has no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

A select output is high whenever the address falls on one of the two claimed locations. The surrounding system uses it to keep main memory off the read bus there. A read of the data location does not simply return the latch. Each bit set as output returns the latched value, and each bit set as input returns the live pin.

Top module: `iop_cpu_port`

## Requirements
- R1: After reset the direction register is 0x00 and the data latch is 0xFF. So pin_oe reads 0x00, pin_out reads 0x00, a read of address 0x0000 returns 0x00, and a read of address 0x0001 returns pin_in.
- R2: A write with cpu_we high at address 0x0000 loads the direction register on that clock edge. From the next cycle, a read of address 0x0000 returns the written byte.
- R3: A write with cpu_we high at address 0x0001 loads the data latch on that clock edge. The direction register is left unchanged.
- R4: A read of address 0x0001 returns, for each bit i, latch[i] when direction[i] is 1 and pin_in[i] when direction[i] is 0. The result appears combinationally in the same cycle.
- R5: pin_out always equals latch AND direction, so a bit configured as input is driven low on pin_out.
- R6: pin_oe always equals the direction register; bit value 1 means output.
- R7: port_sel is high exactly when cpu_addr is 0x0000 or 0x0001.
- R8: A write to any other address changes neither register. A read of any other address returns 0x00 on cpu_rdata.
- R9: In a cycle with cpu_we low, both registers keep their values.
- R10: The latch keeps its value while its bits are inputs. When a bit is later switched to output, the previously latched value appears on pin_out without rewriting the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | Write strobe, taken at the clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data |
| port_sel | output | 1 | High when the address hits the port |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Value driven on output pins |
| pin_oe | output | 8 | Per-bit output enable (1 = drive) |

## Verification
Random traffic is weighted toward the two claimed addresses. It is mixed with random addresses elsewhere, random pin levels and random direction masks. A run of mixed masks separates a correct per-bit merge from a design that returns only the latch or only the pins. Writes to unclaimed addresses followed by read-back show whether the decoder aliases on upper address bits. A directed sequence leaves the reset latch untouched and then switches directions to output, which checks that the latch keeps its value independently of the direction register.

// File: rtl/iop_pkg.sv
package iop_pkg;
  // Which register the current CPU address hits.
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_DIR  = 2'd1,
    HIT_DATA = 2'd2
  } iop_hit_e;
endpackage

// File: rtl/iop_addr_decode.sv
module iop_addr_decode
  import iop_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output iop_hit_e          hit,
  output logic              sel
);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  always_comb begin
    if (addr == DIR_A)       hit = HIT_DIR;
    else if (addr == DATA_A) hit = HIT_DATA;
    else                     hit = HIT_NONE;
  end

  assign sel = (hit != HIT_NONE);
endmodule

// File: rtl/iop_regs.sv
module iop_regs
  import iop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] DIR_RST   = '0,
  parameter logic [DATA_W-1:0] LATCH_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  iop_hit_e          hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] latch_q
);
  logic wr_dir, wr_data;
  assign wr_dir  = we && (hit == HIT_DIR);
  assign wr_data = we && (hit == HIT_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= DIR_RST;
      latch_q <= LATCH_RST;
    end else begin
      if (wr_dir)  dir_q   <= wdata;
      if (wr_data) latch_q <= wdata;
    end
  end
endmodule

// File: rtl/iop_read_merge.sv
module iop_read_merge
  import iop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  iop_hit_e          hit,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0] latch_q,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] drive
);
  logic [DATA_W-1:0] data_view;

  // Per-bit choice between the latched value and the live pin.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_view[i] = dir_q[i] ? latch_q[i] : pin_in[i];
    assign drive[i]     = dir_q[i] & latch_q[i];
  end

  always_comb begin
    unique case (hit)
      HIT_DIR:  rdata = dir_q;
      HIT_DATA: rdata = data_view;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/iop_cpu_port.sv
module iop_cpu_port
  import iop_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              port_sel,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  iop_hit_e          hit;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] latch_q;

  iop_addr_decode #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(cpu_addr), .hit(hit), .sel(port_sel)
  );

  iop_regs #(
    .DATA_W(DATA_W), .DIR_RST('0), .LATCH_RST('1)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cpu_we), .hit(hit), .wdata(cpu_wdata),
    .dir_q(dir_q), .latch_q(latch_q)
  );

  iop_read_merge #(.DATA_W(DATA_W)) u_merge (
    .hit(hit), .dir_q(dir_q), .latch_q(latch_q), .pin_in(pin_in),
    .rdata(cpu_rdata), .drive(pin_out)
  );

  assign pin_oe = dir_q;
endmodule

// File: rtl/iop_cpu_port_chk.sv
module iop_cpu_port_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              port_sel,
  input logic [DATA_W-1:0] pin_in,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_oe
);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == '0 && pin_out == '0)); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == DIR_A) |=> (pin_oe == $past(cpu_wdata))); // R2
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == DATA_A) |=> (pin_out == ($past(cpu_wdata) & pin_oe) && $stable(pin_oe))); // R3
  AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == DATA_A) |-> (((cpu_rdata ^ pin_in) & ~pin_oe) == '0)); // R4
  AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R5
  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == DIR_A) |-> (cpu_rdata == pin_oe)); // R6
  AST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel == (cpu_addr == DIR_A || cpu_addr == DATA_A)); // R7
  AST_UNCLAIMED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !port_sel |-> (cpu_rdata == '0)); // R8
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we || !port_sel) |=> ($stable(pin_oe) && $stable(pin_out))); // R9
endmodule

bind iop_cpu_port iop_cpu_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .port_sel(port_sel),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_iop_cpu_port.sv
module tb_iop_cpu_port;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_we = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          port_sel;
  logic [DW-1:0] pin_in = '0;
  logic [DW-1:0] pin_out;
  logic [DW-1:0] pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_dir;
  logic [DW-1:0] m_latch;

  always #5 clk = ~clk;

  iop_cpu_port dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .port_sel(port_sel),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [DW-1:0] d,
                                              logic [DW-1:0] l, logic [DW-1:0] p);
    if (a == 16'h0000) return d;
    if (a == 16'h0001) return (d & l) | (~d & p);
    return '0;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive at negedge, check after settling, commit model at posedge.
  task automatic step(logic [AW-1:0] a, logic we, logic [DW-1:0] wd, logic [DW-1:0] p);
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; pin_in = p;
    #1;
    chk("R4/R8 read", cpu_rdata, exp_read(a, m_dir, m_latch, p));
    chk("R7 select", {7'b0, port_sel}, {7'b0, (a == 16'h0000 || a == 16'h0001)});
    chk("R6 oe", pin_oe, m_dir);
    chk("R5 out", pin_out, m_latch & m_dir);
    @(posedge clk);
    if (we && a == 16'h0000) m_dir = wd;      // R2
    if (we && a == 16'h0001) m_latch = wd;    // R3
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_dir = 8'h00; m_latch = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    step(16'h0000, 1'b0, 8'h00, 8'hA5);
    chk("R1 oe", pin_oe, 8'h00);
    step(16'h0001, 1'b0, 8'h00, 8'h3C);
    chk("R1 out", pin_out, 8'h00);
    // R10: latch kept from reset, then exposed by direction switch
    step(16'h0000, 1'b1, 8'h0F, 8'h00);
    step(16'h0001, 1'b0, 8'h00, 8'h00);
    chk("R10 latched", pin_out, 8'h0F);
    chk("R10 read", cpu_rdata, 8'h0F);
    // R3: data write leaves direction untouched
    step(16'h0001, 1'b1, 8'h5A, 8'hFF);
    step(16'h0001, 1'b0, 8'h00, 8'hF0);
    chk("R3 dir kept", pin_oe, 8'h0F);
    chk("R4 merge", cpu_rdata, 8'hFA);
    // R8: writes elsewhere ignored, including aliases on upper bits
    step(16'h0100, 1'b1, 8'h00, 8'h00);
    step(16'hFFFF, 1'b1, 8'hFF, 8'h00);
    step(16'h0002, 1'b1, 8'h77, 8'h00);
    step(16'h0000, 1'b0, 8'h00, 8'h00);
    chk("R8 dir kept", cpu_rdata, 8'h0F);
    // R9: idle cycles with write data wiggling
    step(16'h0001, 1'b0, 8'h12, 8'h00);
    chk("R9 latch kept", pin_out, 8'h0A);
    // R2: direction read-back
    step(16'h0000, 1'b1, 8'hC3, 8'h00);
    step(16'h0000, 1'b0, 8'h00, 8'h00);
    chk("R2 dir read", cpu_rdata, 8'hC3);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 9));
      logic [AW-1:0] a;
      if (r < 4) a = 16'h0000;
      else if (r < 8) a = 16'h0001;
      else a = AW'($urandom);
      step(a, 1'($urandom), DW'($urandom), DW'($urandom));
    end
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule